// File: doc/BRIEF.md
# Complex-Integer Execution Pipe with Occupying Write-Back

This block is the complex-integer lane of an in-order core. It holds four registered steps: a dispatch holding slot, first execute, second execute and a final write-back step. It takes at most one operation per cycle. Each operation carries a class code, a destination tag and two 32-bit operands. Plain additions produce their value at the end of first execute, and a one-cycle forward event announces it.

The multiply forms, the divide and the special-register move carry on into write-back and compute or wait there. A divide runs a restoring radix-2 quotient loop and keeps write-back for 33 cycles. A register move keeps write-back for 3 cycles. Upstream steps hold in turn while write-back is busy, and dispatch sees this as a low ready signal.

A multiply-accumulate needs a late accumulator value. It waits for that value in first execute, not at dispatch. Every operation ends with exactly one completion pulse carrying its tag and value, and completions come out in issue order.

Top module: `cip_pipe`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_valid` and `fwd_valid` are 0.
- R2: Class codes 0 and 7 return `in_a + in_b` modulo 2^32. In an idle pipe, an operation accepted at the edge ending cycle t gives `fwd_valid` with its tag and value in cycle t+3 and `res_valid` in cycle t+4. `fwd_valid` does not fire for the other classes.
- R3: Code 1 returns the low 32 bits of the product, code 2 the high 32 bits of the unsigned product, and code 3 the high 32 bits of the signed product. Each completes in cycle t+4 when idle.
- R4: Code 5 returns the unsigned quotient `in_a / in_b`, or 0xFFFFFFFF when `in_b` is 0. It holds write-back for 33 cycles, so when idle it completes in cycle t+36.
- R5: Code 6 returns `in_a` and holds write-back for 3 cycles, so when idle it completes in cycle t+6.
- R6: Code 4 returns the low 32 bits of `in_a * in_b + acc_data`, with `acc_data` taken in the cycle it leaves first execute. While `acc_rdy` is 0 it stays in first execute, no later result appears, and dispatch fills and then drops `in_ready`. When idle with `acc_rdy` high it completes in cycle t+4.
- R7: While write-back is held, the second execute step, the first execute step and dispatch hold in turn, and `in_ready` falls once dispatch is full. No operation is lost, duplicated or reordered.
- R8: Each accepted operation gives exactly one `res_valid` cycle, and no pulse appears without an accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation offered |
| in_op | input | 3 | Class code |
| in_tag | input | TAG_W | Destination tag |
| in_a | input | W | First operand / dividend |
| in_b | input | W | Second operand / divisor |
| in_ready | output | 1 | Dispatch slot can accept this cycle |
| acc_rdy | input | 1 | Accumulator value valid |
| acc_data | input | W | Accumulator value |
| fwd_valid | output | 1 | Early result event for plain adds |
| fwd_tag | output | TAG_W | Tag of the early result |
| fwd_data | output | W | Early result value |
| res_valid | output | 1 | Completion pulse |
| res_tag | output | TAG_W | Completion tag |
| res_data | output | W | Completion value |

## Verification
The bench sweeps edge-value operand pairs through every multiply form and the divide. The pairs include zero, one, the signed extremes and all ones, so a wrong sign extension or an off-by-one quotient bit shows up as a wrong value. It times each class from an idle pipe: an occupancy counter off by one moves the completion cycle, and a divide that does not block lets later operations overtake it. It starves the accumulator while other operations queue behind the multiply-accumulate. A pipe that held at dispatch instead, or let a younger result escape, is caught by the ready check and the ordering scoreboard. A long mixed stream then checks that the backpressure drops nothing and duplicates nothing.

// File: rtl/cip_pkg.sv
package cip_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_MULLO = 3'd1,
        OP_MULHU = 3'd2,
        OP_MULHS = 3'd3,
        OP_MAC   = 3'd4,
        OP_DIV   = 3'd5,
        OP_SPR   = 3'd6,
        OP_ADD2  = 3'd7
    } op_e;
endpackage

// File: rtl/cip_div_step.sv
module cip_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        diff    = shifted - {1'b0, dvs_i};
        if (!diff[W]) begin
            rem_o = diff[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b1};
        end else begin
            rem_o = shifted[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/cip_wb.sv
module cip_wb
    import cip_pkg::*;
#(
    parameter int W       = 32,
    parameter int TAG_W   = 5,
    parameter int SPR_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  op_e              ld_op,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [W-1:0]     ld_a,
    input  logic [W-1:0]     ld_b,
    input  logic [W-1:0]     ld_c,
    output logic             free,
    output logic             busy_valid,
    output op_e              busy_op,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [W-1:0]     res_data
);
    localparam int CNT_W = $clog2(W + SPR_CYC + 1);
    localparam logic [CNT_W-1:0] DIV_CNT = CNT_W'(W);
    localparam logic [CNT_W-1:0] SPR_CNT = CNT_W'(SPR_CYC - 1);

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [TAG_W-1:0] tag;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [W-1:0]     c;
        logic [CNT_W-1:0] cnt;
    } wb_t;

    wb_t wb_d, wb_q;
    logic [W-1:0]   rem_nx, quo_nx;
    logic [2*W-1:0] prod_u, prod_s;
    logic           done;

    cip_div_step #(.W(W)) u_step (
        .rem_i(wb_q.c), .quo_i(wb_q.a), .dvs_i(wb_q.b),
        .rem_o(rem_nx), .quo_o(quo_nx)
    );

    always_comb begin
        wb_d = wb_q;
        done = wb_q.valid && (wb_q.cnt == '0);
        if (wb_q.valid && wb_q.cnt != '0) begin
            wb_d.cnt = wb_q.cnt - 1'b1;
            if (wb_q.op == OP_DIV) begin
                wb_d.c = rem_nx;
                wb_d.a = quo_nx;
            end
        end else if (done) begin
            wb_d.valid = 1'b0;
        end
        if (load) begin
            wb_d.valid = 1'b1;
            wb_d.op    = ld_op;
            wb_d.tag   = ld_tag;
            wb_d.a     = ld_a;
            wb_d.b     = ld_b;
            wb_d.c     = (ld_op == OP_DIV) ? '0 : ld_c;
            wb_d.cnt   = (ld_op == OP_DIV) ? DIV_CNT :
                         (ld_op == OP_SPR) ? SPR_CNT : '0;
        end
    end

    always_comb begin
        prod_u = {{W{1'b0}}, wb_q.a} * {{W{1'b0}}, wb_q.b};
        prod_s = {{W{wb_q.a[W-1]}}, wb_q.a} * {{W{wb_q.b[W-1]}}, wb_q.b};
        unique case (wb_q.op)
            OP_MULLO: res_data = prod_u[W-1:0];
            OP_MULHU: res_data = prod_u[2*W-1:W];
            OP_MULHS: res_data = prod_s[2*W-1:W];
            OP_MAC:   res_data = prod_u[W-1:0] + wb_q.c;
            OP_DIV:   res_data = wb_q.a;
            OP_SPR:   res_data = wb_q.a;
            default:  res_data = wb_q.c;
        endcase
    end

    assign free       = !wb_q.valid || done;
    assign res_valid  = done;
    assign res_tag    = wb_q.tag;
    assign busy_valid = wb_q.valid;
    assign busy_op    = wb_q.op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end
endmodule

// File: rtl/cip_pipe.sv
module cip_pipe
    import cip_pkg::*;
#(
    parameter int W       = 32,
    parameter int TAG_W   = 5,
    parameter int SPR_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    output logic             in_ready,
    input  logic             acc_rdy,
    input  logic [W-1:0]     acc_data,
    output logic             fwd_valid,
    output logic [TAG_W-1:0] fwd_tag,
    output logic [W-1:0]     fwd_data,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [W-1:0]     res_data
);
    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [TAG_W-1:0] tag;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [W-1:0]     c;
    } stg_t;

    typedef struct packed {
        stg_t             rf;
        stg_t             x1;
        stg_t             x2;
        logic             fv;
        logic [TAG_W-1:0] ftag;
        logic [W-1:0]     fdata;
    } st_t;

    st_t  st_d, st_q;
    logic wb_free, x2_go, x1_go, rf_go, x1_simple;
    logic wb_valid;
    op_e  wb_op;
    logic ex1_valid, ex2_valid;
    op_e  ex1_op;
    logic [TAG_W-1:0] ex2_tag;

    always_comb begin
        st_d      = st_q;
        x1_simple = (st_q.x1.op == OP_ADD) || (st_q.x1.op == OP_ADD2);
        x2_go     = st_q.x2.valid && wb_free;
        x1_go     = st_q.x1.valid && (!st_q.x2.valid || wb_free) &&
                    (st_q.x1.op != OP_MAC || acc_rdy);
        rf_go     = st_q.rf.valid && (!st_q.x1.valid || x1_go);
        in_ready  = !st_q.rf.valid || rf_go;

        if (x2_go) st_d.x2.valid = 1'b0;
        if (x1_go) begin
            st_d.x2 = st_q.x1;
            if (x1_simple)                st_d.x2.c = st_q.x1.a + st_q.x1.b;
            else if (st_q.x1.op == OP_MAC) st_d.x2.c = acc_data;
            st_d.x1.valid = 1'b0;
        end
        if (rf_go) begin
            st_d.x1       = st_q.rf;
            st_d.rf.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.rf.valid = 1'b1;
            st_d.rf.op    = op_e'(in_op);
            st_d.rf.tag   = in_tag;
            st_d.rf.a     = in_a;
            st_d.rf.b     = in_b;
            st_d.rf.c     = '0;
        end
        st_d.fv    = x1_go && x1_simple;
        st_d.ftag  = st_q.x1.tag;
        st_d.fdata = st_q.x1.a + st_q.x1.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cip_wb #(.W(W), .TAG_W(TAG_W), .SPR_CYC(SPR_CYC)) u_wb (
        .clk(clk), .rst_n(rst_n), .load(x2_go),
        .ld_op(st_q.x2.op), .ld_tag(st_q.x2.tag),
        .ld_a(st_q.x2.a), .ld_b(st_q.x2.b), .ld_c(st_q.x2.c),
        .free(wb_free), .busy_valid(wb_valid), .busy_op(wb_op),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    assign fwd_valid = st_q.fv;
    assign fwd_tag   = st_q.ftag;
    assign fwd_data  = st_q.fdata;
    assign ex1_valid = st_q.x1.valid;
    assign ex1_op    = st_q.x1.op;
    assign ex2_valid = st_q.x2.valid;
    assign ex2_tag   = st_q.x2.tag;
endmodule

// File: rtl/cip_pipe_chk.sv
module cip_pipe_chk
    import cip_pkg::*;
#(
    parameter int W       = 32,
    parameter int TAG_W   = 5,
    parameter int SPR_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_valid,
    input op_e              wb_op,
    input logic             res_valid,
    input logic             ex1_valid,
    input op_e              ex1_op,
    input logic             acc_rdy,
    input logic             ex2_valid,
    input logic [TAG_W-1:0] ex2_tag
);
    localparam int OC_W = $clog2(W + SPR_CYC + 2) + 1;
    logic [OC_W-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     occ <= '0;
        else if (!wb_valid || res_valid) occ <= '0;
        else                            occ <= occ + 1'b1;
    end

    p_div_occupy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && wb_op == OP_DIV |-> occ == OC_W'(W));

    p_spr_occupy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && wb_op == OP_SPR |-> occ == OC_W'(SPR_CYC - 1));

    p_single_occupy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && wb_op != OP_SPR && wb_op != OP_DIV |-> occ == '0);

    p_mac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ex1_valid && ex1_op == OP_MAC && !acc_rdy |=> ex1_valid && ex1_op == OP_MAC);

    p_ex2_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ex2_valid && wb_valid && !res_valid |=> ex2_valid && $stable(ex2_tag));
endmodule

bind cip_pipe cip_pipe_chk #(.W(W), .TAG_W(TAG_W), .SPR_CYC(SPR_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_op(wb_op),
    .res_valid(res_valid), .ex1_valid(ex1_valid), .ex1_op(ex1_op),
    .acc_rdy(acc_rdy), .ex2_valid(ex2_valid), .ex2_tag(ex2_tag)
);

// File: tb/cip_pipe_tb_top.sv
module cip_pipe_tb_top;
    localparam logic [31:0] ACC_K = 32'h1357_9BDF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [4:0]  in_tag = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_ready;
    logic        acc_rdy = 1'b1;
    logic [31:0] acc_data = ACC_K;
    logic        fwd_valid, res_valid;
    logic [4:0]  fwd_tag, res_tag;
    logic [31:0] fwd_data, res_data;

    int nchk = 0, nerr = 0, cyc = 0, rp = 0, wp = 0, last_issue = 0;
    bit finished = 0;
    logic [4:0]  tag_ctr = '0;
    logic [4:0]  q_tag [0:255];
    logic [31:0] q_data[0:255];
    int          q_lat [0:255];
    int          q_cyc [0:255];
    string       q_req [0:255];
    logic [31:0] vals [0:7];

    cip_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_tag(in_tag), .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
        .acc_rdy(acc_rdy), .acc_data(acc_data), .fwd_valid(fwd_valid),
        .fwd_tag(fwd_tag), .fwd_data(fwd_data), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [2:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [63:0] pu, ps;
        pu = {32'd0, a} * {32'd0, b};
        ps = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        case (op)
            3'd1: return pu[31:0];
            3'd2: return pu[63:32];
            3'd3: return ps[63:32];
            3'd4: return pu[31:0] + ACC_K;
            3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            3'd6: return a;
            default: return a + b;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd1, 3'd2, 3'd3: return "R3";
            3'd4: return "R6";
            3'd5: return "R4";
            3'd6: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic issue(input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input int lat);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_op = op; in_tag = tag_ctr; in_a = a; in_b = b;
        q_tag[wp[7:0]]  = tag_ctr;
        q_data[wp[7:0]] = model(op, a, b);
        q_lat[wp[7:0]]  = lat;
        q_cyc[wp[7:0]]  = cyc;
        q_req[wp[7:0]]  = req_of(op);
        last_issue = cyc;
        wp++;
        tag_ctr++;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (rp != wp) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard: order (R7), single completion (R8), value and idle latency
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (rp == wp) begin
                check(1'b0, "R8 unexpected result", {27'd0, res_tag}, 32'd0);
            end else begin
                check(res_tag == q_tag[rp[7:0]], "R7 order", {27'd0, res_tag},
                      {27'd0, q_tag[rp[7:0]]});
                check(res_data == q_data[rp[7:0]], q_req[rp[7:0]], res_data,
                      q_data[rp[7:0]]);
                if (q_lat[rp[7:0]] >= 0)
                    check(cyc - q_cyc[rp[7:0]] == q_lat[rp[7:0]],
                          {q_req[rp[7:0]], " latency"},
                          32'(cyc - q_cyc[rp[7:0]]), 32'(q_lat[rp[7:0]]));
                rp++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", rp, wp);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int rp0;
        logic [31:0] lcg;
        vals[0] = 32'h0;        vals[1] = 32'h1;
        vals[2] = 32'h2;        vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
        vals[6] = 32'h1234_5678; vals[7] = 32'hDEAD_BEEF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);
        check(res_valid == 1'b0, "R1 res_valid", {31'd0, res_valid}, 32'd0);
        check(fwd_valid == 1'b0, "R1 fwd_valid", {31'd0, fwd_valid}, 32'd0);

        // R2 simple add: early forward at t+3, completion at t+4
        issue(3'd0, 32'hFFFF_FFF0, 32'h0000_0025, 4);
        while (cyc != last_issue + 3) @(negedge clk);
        check(fwd_valid == 1'b1, "R2 fwd_valid", {31'd0, fwd_valid}, 32'd1);
        check(fwd_data == 32'h0000_0015, "R2 fwd_data", fwd_data, 32'h15);
        drain();
        issue(3'd7, 32'h0000_0100, 32'h0000_0023, 4);
        drain();

        // R3 multiply forms: idle timing, then an edge-value sweep
        for (int op = 1; op <= 3; op++) begin
            issue(3'(op), 32'hFFFF_FFFE, 32'h0000_0003, 4);
            while (cyc != last_issue + 3) @(negedge clk);
            check(fwd_valid == 1'b0, "R2 no fwd for multiply", {31'd0, fwd_valid}, 32'd0);
            drain();
        end
        for (int op = 1; op <= 3; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    issue(3'(op), vals[i], vals[j], -1);
        drain();

        // R4 divide: idle timing, then the sweep including zero divisors
        issue(3'd5, 32'd1000, 32'd7, 36);
        drain();
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                issue(3'd5, vals[i], vals[j], -1);
        drain();

        // R5 register move
        issue(3'd6, 32'hCAFE_F00D, 32'h0, 6);
        drain();

        // R6 multiply-accumulate: idle timing, then accumulator starvation
        issue(3'd4, 32'h0001_0001, 32'h0000_0010, 4);
        drain();
        @(negedge clk) acc_rdy = 1'b0;
        rp0 = rp;
        issue(3'd4, 32'h0000_0300, 32'h0000_0005, -1);
        issue(3'd0, 32'h1, 32'h1, -1);
        repeat (10) @(negedge clk);
        check(in_ready == 1'b0, "R6 dispatch full behind waiting MAC",
              {31'd0, in_ready}, 32'd0);
        check(rp == rp0, "R6 no completion while waiting", 32'(rp), 32'(rp0));
        acc_rdy = 1'b1;
        drain();

        // R7 divide blocks the pipe behind it
        issue(3'd5, 32'hFFFF_FFFF, 32'd3, -1);
        issue(3'd0, 32'd5, 32'd6, -1);
        issue(3'd1, 32'd5, 32'd6, -1);
        issue(3'd6, 32'd9, 32'd0, -1);
        repeat (8) @(negedge clk);
        check(in_ready == 1'b0, "R7 in_ready low while divide occupies",
              {31'd0, in_ready}, 32'd0);
        drain();

        // R7/R8 mixed stream under backpressure
        lcg = 32'h2468_ACE1;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] x, y;
            lcg = lcg * 32'd1664525 + 32'd1013904223; x = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; y = lcg >> (lcg[3:0] + 8);
            issue(3'(lcg[31:29]), x, y, -1);
        end
        drain();
        check(rp == wp, "R8 every operation completed once", 32'(rp), 32'(wp));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule